// File: doc/BRIEF.md
# Fixed-point format converter

The block takes one fixed-point sample per enabled clock and re-expresses it in another fixed-point format. Each side's format is fixed at build time: total width, number of fractional bits, and signed (two's complement) or unsigned. The output may keep fewer or more fractional bits, and fewer or more integer bits, than the input.

When fractional bits are dropped, a run-time quantization select picks one of three modes. Truncation drops the bits, which is a floor. Symmetric rounding sends an exact midpoint away from zero. Convergent rounding sends an exact midpoint to the even neighbour. A run-time overflow select then either clamps an out-of-range rounded value to the output limits or keeps only its low output bits.

A build-time latency inserts a register chain after the conversion logic. A low enable freezes that chain, and a synchronous reset clears it.

Top module: `fxp_convert`

## Requirements
- R1: The input is read with IN_FRAC fractional bits, as signed when IN_SIGNED=1 and unsigned otherwise. The output is formed with OUT_FRAC fractional bits, as signed when OUT_SIGNED=1 and unsigned otherwise. Widening pads zeros on the right and sign-extends (signed input) or zero-extends (unsigned input) on the left. An input of zero gives an output of zero in every mode.
- R2: quantMode encoding is 0 for truncate, 1 for symmetric round, 2 for convergent round, and 3 acts as truncate. Truncate gives the largest representable output value not above the input, which is a floor.
- R3: Symmetric round (quantMode=1) gives the nearest representable value, and an exact midpoint goes to the neighbour of larger magnitude. With 8 input bits and 4 fractional bits converted to 4 output bits and 2 fractional bits, 0x16 gives 4'b0110 and 0xE6 gives 4'b1001.
- R4: Convergent round (quantMode=2) gives the nearest representable value, and an exact midpoint goes to the neighbour whose LSB is 0. In the same format, 0x1A gives 4'b0110, 0x16 gives 4'b0110 and 0xE6 gives 4'b1010.
- R5: With satMode=1, a value above the output maximum gives the maximum, and a value below the output minimum gives the minimum. In particular, a negative signed input converted to an unsigned output gives 0.
- R6: With satMode=0, the output is the low OUT_W bits of the rounded value.
- R7: The overflow rule applies to the value after rounding. For example, 0x1F under symmetric round becomes 2.0, which gives 4'b0111 when saturated and 4'b1000 when wrapped.
- R8: The output follows the conversion of the input applied LATENCY enabled clocks earlier. A cycle with rst=1 clears every stage, so dOut reads 0 afterwards.
- R9: While en=0 and rst=0, dOut and all stage contents hold, whatever dIn does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the delay chain when high |
| quantMode | input | 2 | Quantization select (0 truncate, 1 symmetric, 2 convergent, 3 truncate) |
| satMode | input | 1 | 1 saturates, 0 wraps |
| dIn | input | IN_W | Input sample |
| dOut | output | OUT_W | Converted sample after LATENCY stages |

## Verification
Every 8-bit input pattern is run through every quantization and overflow mode and compared against an integer model. The patterns include the exact midpoints, which separate the two rounding modes from each other and from truncation. Values just below the positive limit show whether overflow is judged before or after the rounding carry. Large positive and most-negative codes separate saturation from wrap, and negative inputs into an unsigned output confirm the clamp to zero. A widening unsigned instance checks the padding, and a staggered sequence of values checks the stage count, the freeze under a low enable and the clearing by reset.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  typedef enum logic [1:0] {
    Q_TRUNC = 2'd0,
    Q_SYM   = 2'd1,
    Q_EVEN  = 2'd2
  } fxp_quant_e;

  typedef struct packed {
    logic roundSym;
    logic roundEven;
    logic satOn;
  } fxp_round_t;

  typedef struct packed {
    logic advance;
    logic clear;
  } fxp_pipe_t;
endpackage

// File: rtl/fxp_ctrl.sv
module fxp_ctrl
  import fxp_pkg::*;
(
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] quantMode,
  input  logic       satMode,
  output fxp_round_t rnd,
  output fxp_pipe_t  pipe
);
  always_comb begin
    rnd.roundSym  = (quantMode == Q_SYM);
    rnd.roundEven = (quantMode == Q_EVEN);
    rnd.satOn     = satMode;
    pipe.clear    = rst;
    pipe.advance  = en & ~rst;
  end
endmodule

// File: rtl/fxp_datapath.sv
module fxp_datapath
  import fxp_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int IN_FRAC    = 4,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_W      = 4,
  parameter int OUT_FRAC   = 2,
  parameter bit OUT_SIGNED = 1'b1
) (
  input  logic [IN_W-1:0]  dIn,
  input  fxp_round_t       rnd,
  output logic [OUT_W-1:0] convVal
);
  localparam int SHIFT_UP = (OUT_FRAC > IN_FRAC) ? OUT_FRAC - IN_FRAC : 0;
  localparam int DROP     = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;
  localparam int BASE_W   = (IN_W + SHIFT_UP > OUT_W) ? IN_W + SHIFT_UP : OUT_W;
  localparam int WW       = BASE_W + 2;
  localparam logic signed [WW-1:0] ONE   = {{(WW-1){1'b0}}, 1'b1};
  localparam logic signed [WW-1:0] MAX_V = OUT_SIGNED ? (ONE <<< (OUT_W-1)) - ONE
                                                      : (ONE <<< OUT_W) - ONE;
  localparam logic signed [WW-1:0] MIN_V = OUT_SIGNED ? -(ONE <<< (OUT_W-1)) : '0;

  logic signed [WW-1:0] extVal, aligned, floorVal, rounded;
  logic roundUp;

  assign extVal   = {{(WW-IN_W){IN_SIGNED && dIn[IN_W-1]}}, dIn};
  assign aligned  = extVal <<< SHIFT_UP;
  assign floorVal = aligned >>> DROP;

  generate
    if (DROP == 0) begin : g_noRound
      assign roundUp = 1'b0;
    end else begin : g_round
      localparam logic [DROP-1:0] HALF = DROP'(1) << (DROP-1);
      logic [DROP-1:0] remBits;
      logic atHalf, aboveHalf, anyRound;
      assign remBits   = aligned[DROP-1:0];
      assign atHalf    = (remBits == HALF);
      assign aboveHalf = (remBits > HALF);
      assign anyRound  = rnd.roundSym | rnd.roundEven;
      assign roundUp   = anyRound & (aboveHalf | (atHalf &
                         ((rnd.roundSym & ~aligned[WW-1]) | (rnd.roundEven & floorVal[0]))));
    end
  endgenerate

  assign rounded = floorVal + {{(WW-1){1'b0}}, roundUp};

  always_comb begin
    if (rnd.satOn && (rounded > MAX_V))      convVal = MAX_V[OUT_W-1:0];
    else if (rnd.satOn && (rounded < MIN_V)) convVal = MIN_V[OUT_W-1:0];
    else                                     convVal = rounded[OUT_W-1:0];
  end
endmodule

// File: rtl/fxp_delay.sv
module fxp_delay
  import fxp_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  fxp_pipe_t    pipe,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  generate
    if (DEPTH == 0) begin : g_comb
      assign dOut = dIn;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (pipe.clear) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (pipe.advance) begin
          stg[0] <= dIn;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign dOut = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fxp_convert.sv
module fxp_convert
  import fxp_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int IN_FRAC    = 4,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_W      = 4,
  parameter int OUT_FRAC   = 2,
  parameter bit OUT_SIGNED = 1'b1,
  parameter int LATENCY    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       quantMode,
  input  logic             satMode,
  input  logic [IN_W-1:0]  dIn,
  output logic [OUT_W-1:0] dOut
);
  fxp_round_t rnd;
  fxp_pipe_t  pipe;
  logic [OUT_W-1:0] convVal;

  fxp_ctrl u_ctrl (
    .rst(rst), .en(en), .quantMode(quantMode), .satMode(satMode),
    .rnd(rnd), .pipe(pipe)
  );

  fxp_datapath #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .IN_SIGNED(IN_SIGNED),
    .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .OUT_SIGNED(OUT_SIGNED)
  ) u_dp (
    .dIn(dIn), .rnd(rnd), .convVal(convVal)
  );

  fxp_delay #(.W(OUT_W), .DEPTH(LATENCY)) u_dly (
    .clk(clk), .pipe(pipe), .dIn(convVal), .dOut(dOut)
  );
endmodule

// File: rtl/fxp_convert_chk.sv
module fxp_convert_chk #(
  parameter int IN_W       = 8,
  parameter int IN_FRAC    = 4,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_W      = 4,
  parameter int OUT_FRAC   = 2,
  parameter bit OUT_SIGNED = 1'b1,
  parameter int LATENCY    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       quantMode,
  input logic             satMode,
  input logic [IN_W-1:0]  dIn,
  input logic [OUT_W-1:0] dOut,
  input logic [OUT_W-1:0] convVal
);
  localparam int DROP = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
    (dIn == '0) |-> (convVal == '0)); // R1

  generate
    if (LATENCY > 0) begin : g_seq
      AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dOut == '0)); // R8
      AST_HOLD_EN: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dOut)); // R9
    end
    if (IN_SIGNED && !OUT_SIGNED) begin : g_negClamp
      AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (satMode && dIn[IN_W-1]) |-> (convVal == '0)); // R5
    end
    if (DROP > 0) begin : g_even
      localparam logic [DROP-1:0] HALF = DROP'(1) << (DROP-1);
      AST_EVEN_MIDPOINT: assert property (@(posedge clk) disable iff (rst)
        (quantMode == 2'd2 && !satMode && dIn[DROP-1:0] == HALF) |-> (convVal[0] == 1'b0)); // R4
    end
  endgenerate
endmodule

bind fxp_convert fxp_convert_chk #(
  .IN_W(IN_W), .IN_FRAC(IN_FRAC), .IN_SIGNED(IN_SIGNED),
  .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .OUT_SIGNED(OUT_SIGNED), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .quantMode(quantMode), .satMode(satMode),
  .dIn(dIn), .dOut(dOut), .convVal(convVal)
);

// File: tb/fxp_convert_bench.sv
`timescale 1ns/1ps
module fxp_convert_bench;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic [1:0] quantMode = 2'd0;
  logic satMode = 1'b0;
  logic [7:0] dIn = 8'h00;
  logic [3:0] dOut, dOutU;
  logic [11:0] dOutW;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fxp_convert #(.IN_W(8), .IN_FRAC(4), .IN_SIGNED(1'b1), .OUT_W(4), .OUT_FRAC(2),
                .OUT_SIGNED(1'b1), .LATENCY(LAT)) u_fxp_convert (
    .clk(clk), .rst(rst), .en(en), .quantMode(quantMode), .satMode(satMode),
    .dIn(dIn), .dOut(dOut));

  fxp_convert #(.IN_W(8), .IN_FRAC(4), .IN_SIGNED(1'b1), .OUT_W(4), .OUT_FRAC(2),
                .OUT_SIGNED(1'b0), .LATENCY(0)) u_fxp_convert_uns (
    .clk(clk), .rst(rst), .en(en), .quantMode(quantMode), .satMode(satMode),
    .dIn(dIn), .dOut(dOutU));

  fxp_convert #(.IN_W(8), .IN_FRAC(4), .IN_SIGNED(1'b0), .OUT_W(12), .OUT_FRAC(6),
                .OUT_SIGNED(1'b1), .LATENCY(0)) u_fxp_convert_wid (
    .clk(clk), .rst(rst), .en(en), .quantMode(quantMode), .satMode(satMode),
    .dIn(dIn), .dOut(dOutW));

  // Integer model: 8-bit input with 4 fractional bits into 4 bits with 2 fractional bits
  function automatic logic [3:0] refConv(logic [7:0] x, int q, bit s, bit outSigned);
    int v, fl, rem, r, lo, hi;
    v = $signed(x);
    fl = v >>> 2;
    rem = v - fl * 4;
    r = fl;
    if (q == 1 && (rem > 2 || (rem == 2 && v >= 0))) r = fl + 1;
    if (q == 2 && (rem > 2 || (rem == 2 && (fl % 2 != 0)))) r = fl + 1;
    lo = outSigned ? -8 : 0;
    hi = outSigned ? 7 : 15;
    if (s && r > hi) r = hi;
    if (s && r < lo) r = lo;
    return 4'(r & 15);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] x, logic [1:0] q, bit s);
    @(negedge clk);
    dIn = x; quantMode = q; satMode = s;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R8 reset state", {12'h0, dOut}, 16'h0);
  endtask

  task automatic testMidpoints();
    apply(8'h16, 2'd0, 1'b0); check("R2 trunc 0x16", {12'h0, dOut}, 16'h5);
    apply(8'h16, 2'd1, 1'b0); check("R3 sym 0x16", {12'h0, dOut}, 16'h6);
    apply(8'h16, 2'd2, 1'b0); check("R4 even 0x16", {12'h0, dOut}, 16'h6);
    apply(8'h1A, 2'd1, 1'b0); check("R3 sym 0x1A", {12'h0, dOut}, 16'h7);
    apply(8'h1A, 2'd2, 1'b0); check("R4 even 0x1A", {12'h0, dOut}, 16'h6);
    apply(8'h1A, 2'd3, 1'b0); check("R2 mode3 0x1A", {12'h0, dOut}, 16'h6);
    apply(8'hE6, 2'd0, 1'b0); check("R2 trunc 0xE6", {12'h0, dOut}, 16'h9);
    apply(8'hE6, 2'd1, 1'b0); check("R3 sym 0xE6", {12'h0, dOut}, 16'h9);
    apply(8'hE6, 2'd2, 1'b0); check("R4 even 0xE6", {12'h0, dOut}, 16'hA);
  endtask

  task automatic testOverflow();
    apply(8'h1F, 2'd1, 1'b1); check("R7 round carry sat", {12'h0, dOut}, 16'h7);
    apply(8'h1F, 2'd1, 1'b0); check("R7 round carry wrap", {12'h0, dOut}, 16'h8);
    apply(8'h1F, 2'd0, 1'b1); check("R7 trunc no carry", {12'h0, dOut}, 16'h7);
    apply(8'h70, 2'd0, 1'b1); check("R5 sat high", {12'h0, dOut}, 16'h7);
    apply(8'h70, 2'd0, 1'b0); check("R6 wrap high", {12'h0, dOut}, 16'hC);
    apply(8'h80, 2'd0, 1'b1); check("R5 sat low", {12'h0, dOut}, 16'h8);
    apply(8'h80, 2'd0, 1'b0); check("R6 wrap low", {12'h0, dOut}, 16'h0);
    apply(8'hE6, 2'd1, 1'b1); check("R5 neg to unsigned", {12'h0, dOutU}, 16'h0);
    apply(8'hE6, 2'd1, 1'b0); check("R6 neg to unsigned wrap", {12'h0, dOutU}, 16'h9);
  endtask

  task automatic testWiden();
    apply(8'hF0, 2'd1, 1'b1); check("R1 widen zero-extend", {4'h0, dOutW}, 16'h03C0);
    apply(8'h00, 2'd2, 1'b1); check("R1 zero in", {12'h0, dOut}, 16'h0);
  endtask

  task automatic testSweep();
    for (int x = 0; x < 256; x++) begin
      for (int q = 0; q < 3; q++) begin
        for (int s = 0; s < 2; s++) begin
          string tag;
          apply(8'(x), 2'(q), 1'(s));
          tag = (q == 0) ? "R2 sweep" : (q == 1) ? "R3 sweep" : "R4 sweep";
          check(tag, {12'h0, dOut}, {12'h0, refConv(8'(x), q, 1'(s), 1'b1)});
          check(s ? "R5 sweep unsigned" : "R6 sweep unsigned",
                {12'h0, dOutU}, {12'h0, refConv(8'(x), q, 1'(s), 1'b0)});
          check("R1 sweep widen", {4'h0, dOutW}, {6'h0, 8'(x), 2'b00});
        end
      end
    end
  endtask

  task automatic testLatencyHold();
    apply(8'h10, 2'd0, 1'b0);                  // 1.0 -> 4'h4
    @(negedge clk); dIn = 8'h20;               // 2.0 -> wraps to 4'h8
    @(posedge clk); @(negedge clk);
    check("R8 one stage in flight", {12'h0, dOut}, 16'h4);
    @(posedge clk); @(negedge clk);
    check("R8 after LATENCY clocks", {12'h0, dOut}, 16'h8);
    en = 1'b0; dIn = 8'hF0;                    // -1.0 -> 4'hC
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 hold while disabled", {12'h0, dOut}, 16'h8);
    en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 frozen stage resumes", {12'h0, dOut}, 16'h8);
    @(posedge clk); @(negedge clk);
    check("R8 new value after resume", {12'h0, dOut}, 16'hC);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R8 reset clears stages", {12'h0, dOut}, 16'h0);
    @(posedge clk); @(negedge clk);
    check("R8 refill after reset", {12'h0, dOut}, 16'h0);
    @(posedge clk); @(negedge clk);
    check("R8 refilled", {12'h0, dOut}, 16'hC);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testMidpoints();
    testOverflow();
    testWiden();
    testLatencyHold();
    testSweep();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule